// File: doc/BRIEF.md
# Daisy-Chain Converter Reader

This block is the host-side controller for a chain of serial analog-to-digital converters. All of them share one conversion-start line and forward their data through each other. When the host raises a start request, the block fires one shared start strobe, so every converter in the chain samples at the same instant. It then follows the converters' shared BUSY line: first BUSY rising, then BUSY falling.

Only after BUSY has fallen does the block drop the chip-select and read-enable lines and run a burst of serial clock pulses. The burst has exactly 16 pulses per chained device. The clock is discontinuous: it stays at its idle level outside the burst, so no digital edge lands while a conversion is in progress. The captured stream is one long concatenation of device words. The block splits it back into one word per device and hands the words out one at a time, in chain order, over a valid/ready port.

The serial clock rate comes from a half-period divider input, and the idle level of the clock is selectable. Start requests that arrive while a read is still going on are remembered and served once the last word has been accepted.

Top module: `chain_adc_reader`

## Requirements
- R1: While reset is held and directly after it, `cs_n` and `rd_n` are 1, `cnv_start` and `word_valid` are 0, and `sclk` sits at the level selected by `sclk_idle_hi`.
- R2: A `start_req` seen in the idle state makes `cnv_start` high for exactly one clock, in the cycle after the request.
- R3: `sclk` does not change in any cycle that follows a cycle where `busy` is high, and no read starts until `busy` has gone high and then low after the start strobe.
- R4: After `busy` falls, `cs_n` and `rd_n` drop together, exactly 16·N_DEV clock pulses are issued while they are low, and both return to 1 with the final pulse.
- R5: From the fall of `cs_n`, every `sclk` level lasts exactly `sclk_div`+1 system clocks, using the divider value held when `busy` fell. A change to `sclk_div` during a read has no effect on that read.
- R6: Outside a read, `sclk` equals `sclk_idle_hi`. A pulse is one move away from the idle level (the leading edge) followed by one move back. `sdo` is sampled on each leading edge, and the chain is expected to change its data on the edge back to idle.
- R7: The first 16 bits received, MSB first, form word 0, which comes from the device nearest the host. Word k is formed by bits 16k to 16k+15 of the stream. Words are emitted in order 0 to N_DEV-1, with `word_idx` equal to k, and `word_valid` drops after the last one.
- R8: While `word_valid` is high and `word_ready` is low, `word_valid`, `word_data` and `word_idx` hold. The block moves to the next word only on a cycle where both are high.
- R9: Any number of `start_req` pulses during a conversion, read or emission collapse into a single further start strobe. That strobe is issued after the last word is accepted, and `cnv_start` never goes high while `cs_n` is low or `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_req | input | 1 | Request one shared conversion and read |
| sclk_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| sclk_idle_hi | input | 1 | Idle level of the serial clock |
| cnv_start | output | 1 | Shared conversion-start strobe to all devices |
| busy | input | 1 | Conversion in progress, from the chain |
| cs_n | output | 1 | Active-low chip select |
| rd_n | output | 1 | Active-low read enable |
| sclk | output | 1 | Discontinuous serial clock |
| sdo | input | 1 | Serial data from the nearest device |
| word_data | output | WORD_W | Current device word |
| word_idx | output | IDX_W | Chain position of the current word, 0 = nearest |
| word_valid | output | 1 | `word_data` holds a word |
| word_ready | input | 1 | Consumer accepts the current word |

## Verification
The bench sweeps three divider values, both idle levels and several data patterns. Each pattern places the 8001/7FFE and FFFF/0000 boundaries across device seams. It measures every serial clock level against the divider, so a pulse counter that is off by one shows up as 47 or 49 leading edges instead of 48, and a divider that is not latched breaks the half-period check when the bench changes `sclk_div` mid-read. The bench also counts clock transitions while BUSY is high, and checks at the ports that stalled words hold. A reversed split would hand out the upstream word first, and a dropped pending request would leave the conversion count one short. Repeated requests during a read must produce exactly one extra conversion; a design that queues each request would instead show a count that keeps growing.

// File: rtl/cdr_pkg.sv
package cdr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_WAIT_HI,
    ST_WAIT_LO,
    ST_SHIFT,
    ST_EMIT
  } rd_state_t;

  // Total serial bits collected from a chain of n devices of w bits each.
  function automatic int chain_bits(input int n, input int w);
    return n * w;
  endfunction

  // Bit offset of device word k inside the captured vector (word 0 arrives first,
  // so it ends up in the most significant slice).
  function automatic int word_base(input int k, input int n, input int w);
    return (n - 1 - k) * w;
  endfunction

endpackage

// File: rtl/cdr_halfper.sv
module cdr_halfper #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);

  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == div_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cdr_shifter.sv
module cdr_shifter
  import cdr_pkg::*;
#(
  parameter int N_DEV  = 3,
  parameter int WORD_W = 16,
  localparam int TOTAL = chain_bits(N_DEV, WORD_W),
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             tick,
  input  logic             sdo,
  output logic             sclk_act,
  output logic             lead_edge,
  output logic             trail_edge,
  output logic             done,
  output logic [TOTAL-1:0] chain_q
);

  logic             act_q;
  logic [CNT_W-1:0] pulses_q;

  assign sclk_act   = act_q;
  assign lead_edge  = active && tick && !act_q;
  assign trail_edge = active && tick && act_q;
  assign done       = trail_edge && (pulses_q == CNT_W'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      pulses_q <= '0;
      chain_q  <= '0;
    end else if (!active) begin
      act_q    <= 1'b0;
      pulses_q <= '0;
    end else begin
      if (lead_edge) begin
        act_q   <= 1'b1;
        chain_q <= {chain_q[TOTAL-2:0], sdo};
      end
      if (trail_edge) begin
        act_q    <= 1'b0;
        pulses_q <= pulses_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/cdr_emitter.sv
module cdr_emitter
  import cdr_pkg::*;
#(
  parameter int N_DEV  = 3,
  parameter int WORD_W = 16,
  parameter int IDX_W  = 2,
  localparam int TOTAL = chain_bits(N_DEV, WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TOTAL-1:0]  chain_q,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] data,
  output logic [IDX_W-1:0]  idx,
  output logic              last_hs
);

  logic             v_q;
  logic [IDX_W-1:0] idx_q;

  function automatic logic [WORD_W-1:0] pick(input logic [TOTAL-1:0] c,
                                             input logic [IDX_W-1:0] k);
    return c[word_base(int'(k), N_DEV, WORD_W) +: WORD_W];
  endfunction

  assign valid   = v_q;
  assign idx     = idx_q;
  assign data    = pick(chain_q, idx_q);
  assign last_hs = v_q && ready && (idx_q == IDX_W'(N_DEV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      idx_q <= '0;
    end else if (load) begin
      v_q   <= 1'b1;
      idx_q <= '0;
    end else if (v_q && ready) begin
      if (last_hs) begin
        v_q <= 1'b0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/chain_adc_reader.sv
module chain_adc_reader
  import cdr_pkg::*;
#(
  parameter int N_DEV  = 3,
  parameter int WORD_W = 16,
  parameter int DIV_W  = 8,
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1,
  localparam int TOTAL = chain_bits(N_DEV, WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic [DIV_W-1:0]  sclk_div,
  input  logic              sclk_idle_hi,
  output logic              cnv_start,
  input  logic              busy,
  output logic              cs_n,
  output logic              rd_n,
  output logic              sclk,
  input  logic              sdo,
  output logic [WORD_W-1:0] word_data,
  output logic [IDX_W-1:0]  word_idx,
  output logic              word_valid,
  input  logic              word_ready
);

  rd_state_t        state_q, state_d;
  logic             pend_q;
  logic [DIV_W-1:0] div_q;

  // Named internal events
  logic             launch;
  logic             busy_done;
  logic             shift_active;
  logic             half_tick;
  logic             sclk_act;
  logic             lead_edge;
  logic             trail_edge;
  logic             read_done;
  logic             emit_done;
  logic [TOTAL-1:0] chain_q;

  assign launch       = (state_q == ST_IDLE) && (start_req || pend_q);
  assign busy_done    = (state_q == ST_WAIT_LO) && !busy;
  assign shift_active = (state_q == ST_SHIFT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (launch)     state_d = ST_CONV;
      ST_CONV:                    state_d = ST_WAIT_HI;
      ST_WAIT_HI: if (busy)       state_d = ST_WAIT_LO;
      ST_WAIT_LO: if (busy_done)  state_d = ST_SHIFT;
      ST_SHIFT:   if (read_done)  state_d = ST_EMIT;
      ST_EMIT:    if (emit_done)  state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      div_q   <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        pend_q <= 1'b0;
      end else if (start_req) begin
        pend_q <= 1'b1;
      end
      if (busy_done) begin
        div_q <= sclk_div;
      end
    end
  end

  cdr_halfper #(.DIV_W(DIV_W)) u_halfper (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (shift_active),
    .div_val (div_q),
    .tick    (half_tick)
  );

  cdr_shifter #(.N_DEV(N_DEV), .WORD_W(WORD_W)) u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (shift_active),
    .tick       (half_tick),
    .sdo        (sdo),
    .sclk_act   (sclk_act),
    .lead_edge  (lead_edge),
    .trail_edge (trail_edge),
    .done       (read_done),
    .chain_q    (chain_q)
  );

  cdr_emitter #(.N_DEV(N_DEV), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_emitter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (read_done),
    .chain_q (chain_q),
    .ready   (word_ready),
    .valid   (word_valid),
    .data    (word_data),
    .idx     (word_idx),
    .last_hs (emit_done)
  );

  assign cnv_start = (state_q == ST_CONV);
  assign cs_n      = !shift_active;
  assign rd_n      = !shift_active;
  assign sclk      = sclk_act ^ sclk_idle_hi;

endmodule

// File: rtl/cdr_checker.sv
module cdr_checker #(
  parameter int WORD_W = 16,
  parameter int IDX_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cnv_start,
  input logic              busy,
  input logic              cs_n,
  input logic              rd_n,
  input logic              sclk,
  input logic              sclk_idle_hi,
  input logic              lead_edge,
  input logic              trail_edge,
  input logic              word_valid,
  input logic              word_ready,
  input logic [WORD_W-1:0] word_data,
  input logic [IDX_W-1:0]  word_idx
);

  // R2
  cnv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);

  // R3
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sclk));

  // R4
  sel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (!busy && !rd_n));

  // R4
  edge_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lead_edge || trail_edge) |-> !cs_n);

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sclk == sclk_idle_hi));

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready) |=>
      (word_valid && $stable(word_data) && $stable(word_idx)));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |-> (cs_n && !word_valid));

endmodule

bind chain_adc_reader cdr_checker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cnv_start    (cnv_start),
  .busy         (busy),
  .cs_n         (cs_n),
  .rd_n         (rd_n),
  .sclk         (sclk),
  .sclk_idle_hi (sclk_idle_hi),
  .lead_edge    (lead_edge),
  .trail_edge   (trail_edge),
  .word_valid   (word_valid),
  .word_ready   (word_ready),
  .word_data    (word_data),
  .word_idx     (word_idx)
);

// File: tb/chain_adc_reader_tb.sv
`timescale 1ns/1ps
module chain_adc_reader_tb;
  localparam int N    = 3;
  localparam int W    = 16;
  localparam int DW   = 8;
  localparam int TOT  = N * W;
  localparam int IW   = $clog2(N);
  localparam int CONV = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0;
  logic idle_hi = 1'b0;
  logic busy = 1'b0;
  logic word_ready = 1'b0;
  logic [DW-1:0] div_cfg = '0;
  logic cnv_start, cs_n, rd_n, sclk, sdo, word_valid;
  logic [W-1:0] word_data;
  logic [IW-1:0] word_idx;

  int checks = 0;
  int fails = 0;
  int conv_count = 0;
  int busy_cnt = 0;

  always #2.5 clk = ~clk;

  chain_adc_reader #(.N_DEV(N), .WORD_W(W), .DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .sclk_div(div_cfg),
    .sclk_idle_hi(idle_hi), .cnv_start(cnv_start), .busy(busy), .cs_n(cs_n),
    .rd_n(rd_n), .sclk(sclk), .sdo(sdo), .word_data(word_data),
    .word_idx(word_idx), .word_valid(word_valid), .word_ready(word_ready)
  );

  // Chain model: word 0 (nearest device) leaves first, MSB first; the
  // chain changes its output bit when sclk returns to the idle level.
  logic [W-1:0]   exp_w [N];
  logic [TOT-1:0] next_chain = '0;
  int             sh_cnt = 0;
  logic           last_sclk = 1'b0;

  always @(sclk or cs_n) begin
    if (cs_n !== 1'b0) begin
      sh_cnt = 0;
    end else if (sclk !== last_sclk && sclk === idle_hi) begin
      sh_cnt = sh_cnt + 1;
    end
    last_sclk = sclk;
  end
  assign sdo = (sh_cnt < TOT) ? next_chain[TOT-1-sh_cnt] : 1'b0;

  // Busy model
  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      busy_cnt <= 0;
    end else if (cnv_start) begin
      busy <= 1'b1;
      busy_cnt <= CONV;
      conv_count <= conv_count + 1;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
      if (busy_cnt == 1) busy <= 1'b0;
    end
  end

  // Edge monitor
  int   since_ev = 0;
  int   exp_half = 1;
  int   lead_cnt = 0;
  int   half_err = 0;
  int   busy_tog = 0;
  logic prev_sclk = 1'b0;
  logic prev_cs = 1'b1;

  always @(negedge clk) begin
    since_ev = since_ev + 1;
    if (prev_cs === 1'b1 && cs_n === 1'b0) since_ev = 0;
    if (sclk !== prev_sclk && (cs_n === 1'b0 || prev_cs === 1'b0)) begin
      if (busy) busy_tog = busy_tog + 1;
      if (since_ev != exp_half) half_err = half_err + 1;
      if (sclk !== idle_hi) lead_cnt = lead_cnt + 1;
      since_ev = 0;
    end
    prev_sclk = sclk;
    prev_cs = cs_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int sel, input int k);
    case (sel % 3)
      0:       return (k % 2 == 0) ? W'(16'h8001) : W'(16'h7FFE);
      1:       return (k == 0) ? W'(16'hFFFF) : (k == 1) ? W'(16'h0000) : W'(16'hA5A5);
      default: return W'(32'h1357 * (sel + 1) + 32'h2468 * (k + 3));
    endcase
  endfunction

  task automatic load_words(input int sel);
    for (int k = 0; k < N; k++) begin
      exp_w[k] = pat(sel, k);
      next_chain[(N-1-k)*W +: W] = exp_w[k];
    end
  endtask

  task automatic clear_mon();
    @(posedge clk);
    lead_cnt = 0;
    half_err = 0;
    busy_tog = 0;
  endtask

  task automatic issue_start();
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    chk(cnv_start === 1'b1, "R2", "strobe after request", cnv_start, 1);
    @(negedge clk);
    chk(cnv_start === 1'b0, "R2", "strobe one cycle", cnv_start, 0);
  endtask

  task automatic read_words(input int stall_sel);
    int guard = 0;
    while (word_valid !== 1'b1 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    for (int k = 0; k < N; k++) begin
      word_ready = 1'b0;
      repeat ((k + stall_sel) % 3) begin
        @(negedge clk);
        chk(word_valid === 1'b1 && word_data === exp_w[k] && word_idx === IW'(k),
            "R8", "held word", word_data, exp_w[k]);
      end
      word_ready = 1'b1;
      chk(word_data === exp_w[k], "R7", "word value", word_data, exp_w[k]);
      chk(word_idx === IW'(k), "R7", "word index", word_idx, k);
      @(negedge clk);
      word_ready = 1'b0;
    end
    chk(word_valid === 1'b0, "R7", "valid drops after last", word_valid, 0);
  endtask

  task automatic frame_checks(input logic idle);
    chk(lead_cnt == TOT, "R4", "pulse count", lead_cnt, TOT);
    chk(half_err == 0, "R5", "half-period errors", half_err, 0);
    chk(busy_tog == 0, "R3", "sclk moves while busy", busy_tog, 0);
    chk(cs_n === 1'b1 && rd_n === 1'b1, "R4", "select released", {cs_n, rd_n}, 3);
    chk(sclk === idle, "R6", "idle level after read", sclk, idle);
  endtask

  task automatic run_case(input int div, input logic idle, input int sel,
                          input int stall, input bit inject);
    int conv0;
    clear_mon();
    conv0 = conv_count;
    @(negedge clk);
    div_cfg = DW'(div);
    idle_hi = idle;
    exp_half = div + 1;
    load_words(sel);
    @(negedge clk);
    chk(sclk === idle, "R6", "idle level before read", sclk, idle);
    issue_start();
    if (inject) begin
      while (cs_n !== 1'b0) @(negedge clk);
      start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
      div_cfg = DW'(div + 2);   // must not disturb this read (R5)
      @(negedge clk) start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
    end
    read_words(stall);
    frame_checks(idle);
    if (inject) begin
      div_cfg = DW'(div);
      load_words(sel + 1);
      clear_mon();
      read_words(stall + 1);
      frame_checks(idle);
      repeat (60) @(negedge clk);
      chk(conv_count == conv0 + 2, "R9", "requests collapse to one", conv_count, conv0 + 2);
    end else begin
      repeat (10) @(negedge clk);
      chk(conv_count == conv0 + 1, "R2", "one conversion per request", conv_count, conv0 + 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(cs_n === 1'b1 && rd_n === 1'b1, "R1", "select in reset", {cs_n, rd_n}, 3);
    chk(cnv_start === 1'b0 && word_valid === 1'b0, "R1", "strobe/valid in reset",
        {cnv_start, word_valid}, 0);
    chk(sclk === 1'b0, "R1", "sclk idle in reset", sclk, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && cnv_start === 1'b0 && word_valid === 1'b0, "R1",
        "state after reset", {cs_n, cnv_start, word_valid}, 4);
    idle_hi = 1'b1;
    @(negedge clk);
    chk(sclk === 1'b1, "R1", "sclk follows idle select", sclk, 1);
    for (int d = 0; d < 3; d++) begin
      for (int i = 0; i < 2; i++) begin
        for (int p = 0; p < 3; p++) begin
          run_case((d == 2) ? 3 : d, logic'(i), p + d, (p + i) % 3, p == 2);
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule